// File: doc/BRIEF.md
# Predicated 16-bit SIMD Lane ALU

This unit applies one integer operation at a time to a wide vector split into narrow lanes. With the default parameters the vector is 512 bits, seen as thirty-two 16-bit lanes. An operation brings in two source vectors, the current destination vector, a per-lane predicate mask and a 4-bit operation code. Every lane computes the same scalar function on its own slice: wrapping add or subtract, clamped add or subtract, wrapping negate or magnitude, signed or unsigned distance, average rounded upward, or unsigned maximum.

Signedness, clamping and masking are not runtime settings. Each combination has its own operation code. The masked variants write the computed value only into lanes whose predicate bit is set. All other lanes return the destination value that was passed in, so the caller can merge the result into a register. Codes with no assigned meaning leave the destination untouched and raise a flag.

Each accepted operation produces its result vector one clock later, together with a single-cycle valid pulse. A parameter can remove that register and give a same-cycle combinational path instead.

Top module: `simd_lane_alu`

## Requirements
- R1: Code 0 gives (a+b) mod 2^16 and code 1 gives (a-b) mod 2^16 in every lane, and each lane is independent of its neighbours.
- R2: Codes 2 (add) and 3 (subtract) sign-extend both lanes to 17 bits. When bits 16 and 15 of the result differ, the output is clamped: 0x7FFF when bit 16 is 0, and 0x8000 when bit 16 is 1. Otherwise the output is the low 16 bits.
- R3: Code 4 gives (0-a) mod 2^16 and code 5 gives the wrapped magnitude of the signed lane. Both return 0x8000 for an input of 0x8000.
- R4: Code 6 gives |a-b| of the sign-extended lanes and code 7 gives |a-b| of the zero-extended lanes, each keeping the low 16 bits.
- R5: Code 8 gives floor((a+b+1)/2) on a signed 17-bit sum. For example, (3,4)→4, (5,2)→4, (-4,-3)→-3 and (7,8)→8.
- R6: Code 9 returns the larger of the two lanes compared as unsigned numbers, so (0x8000,0x0001)→0x8000.
- R7: Codes 10, 11, 12 and 13 are the masked forms of codes 0, 1, 2 and 8. Predicate bit i controls lane i (bits [16i+15:16i]). When the bit is 1 the lane gets the computed value. When it is 0 the lane gets the destination lane value, not zero.
- R8: Codes 0 to 9 ignore the predicate input completely.
- R9: Codes 14 and 15 return the destination vector unchanged and set the illegal flag high with the result. Codes 0 to 13 leave the flag low.
- R10: An operation is accepted on a clock edge where in_valid and in_ready are both high. out_valid is high for exactly one cycle, on the cycle after acceptance. During reset, out_valid is low, the result is zero and in_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can accept an operation (high after reset) |
| in_op | input | 4 | Operation code |
| in_src_a | input | 512 | First source vector |
| in_src_b | input | 512 | Second source vector |
| in_dst | input | 512 | Current destination vector, used for merging |
| in_pred | input | 32 | Per-lane predicate, one bit per lane |
| out_valid | output | 1 | One-cycle pulse marking a result |
| out_result | output | 512 | Result vector |
| out_illegal | output | 1 | The operation code was unassigned |

## Verification
Each operation is driven with lanes set to the exact boundary values: 0x7FFF, 0x8000, 0xFFFF, 0 and the worked examples. These show whether clamping, wrapping and sign handling are correct at the points where they differ. Pseudo-random vectors from a shift-register generator then cover every code and expose any coupling between lanes. The masked codes are driven with all-clear, all-set and alternating masks, which separates merging from zero-filling. The plain codes are run twice with opposite masks, which shows the mask is ignored. Back-to-back and idle cycles check that exactly one valid pulse follows each accepted operation.

// File: rtl/simd_lane_pkg.sv
package simd_lane_pkg;

    localparam int LANE_W = 16;
    localparam int OP_W   = 4;

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [LANE_W:0]   lane_ext_t;

    localparam lane_t LANE_POS_MAX = {1'b0, {(LANE_W-1){1'b1}}};
    localparam lane_t LANE_NEG_MIN = {1'b1, {(LANE_W-1){1'b0}}};

    // Operation codes: each signedness / clamp / mask choice is its own code
    typedef enum logic [OP_W-1:0] {
        OP_ADD    = 4'd0,
        OP_SUB    = 4'd1,
        OP_ADDS   = 4'd2,
        OP_SUBS   = 4'd3,
        OP_NEG    = 4'd4,
        OP_ABS    = 4'd5,
        OP_ABSD   = 4'd6,
        OP_ABSDU  = 4'd7,
        OP_AVGR   = 4'd8,
        OP_MAXU   = 4'd9,
        OP_ADD_P  = 4'd10,
        OP_SUB_P  = 4'd11,
        OP_ADDS_P = 4'd12,
        OP_AVGR_P = 4'd13
    } op_code_e;

    // Scalar function executed inside one lane
    typedef enum logic [3:0] {
        FN_ADD,
        FN_SUB,
        FN_ADDS,
        FN_SUBS,
        FN_NEG,
        FN_ABS,
        FN_ABSD,
        FN_ABSDU,
        FN_AVGR,
        FN_MAXU,
        FN_KEEP
    } lane_fn_e;

    typedef struct packed {
        lane_fn_e fn;
        logic     merge;
        logic     illegal;
    } op_ctl_t;

    function automatic lane_ext_t sext1(lane_t v);
        return {v[LANE_W-1], v};
    endfunction

    function automatic lane_ext_t zext1(lane_t v);
        return {1'b0, v};
    endfunction

    // Clamp a one-bit-wider signed value back into a lane
    function automatic lane_t clamp_lane(lane_ext_t s);
        lane_t r;
        if (s[LANE_W] != s[LANE_W-1]) begin
            r = s[LANE_W] ? LANE_NEG_MIN : LANE_POS_MAX;
        end else begin
            r = s[LANE_W-1:0];
        end
        return r;
    endfunction

    // Magnitude of a one-bit-wider signed value, low lane bits kept
    function automatic lane_t mag_lane(lane_ext_t d);
        lane_ext_t n;
        n = d[LANE_W] ? (~d + 1'b1) : d;
        return n[LANE_W-1:0];
    endfunction

    // floor((a+b+1)/2) over a signed sum, taken from a two-bit-wider adder
    function automatic lane_t avg_up(lane_t a, lane_t b);
        logic [LANE_W+1:0] s;
        s = {a[LANE_W-1], a[LANE_W-1], a} + {b[LANE_W-1], b[LANE_W-1], b}
            + {{(LANE_W+1){1'b0}}, 1'b1};
        return s[LANE_W:1];
    endfunction

endpackage

// File: rtl/simd_op_decode.sv
module simd_op_decode
    import simd_lane_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output op_ctl_t         ctl
);
    always_comb begin
        ctl.fn      = FN_KEEP;
        ctl.merge   = 1'b0;
        ctl.illegal = 1'b0;
        case (op)
            OP_ADD:    ctl.fn = FN_ADD;
            OP_SUB:    ctl.fn = FN_SUB;
            OP_ADDS:   ctl.fn = FN_ADDS;
            OP_SUBS:   ctl.fn = FN_SUBS;
            OP_NEG:    ctl.fn = FN_NEG;
            OP_ABS:    ctl.fn = FN_ABS;
            OP_ABSD:   ctl.fn = FN_ABSD;
            OP_ABSDU:  ctl.fn = FN_ABSDU;
            OP_AVGR:   ctl.fn = FN_AVGR;
            OP_MAXU:   ctl.fn = FN_MAXU;
            OP_ADD_P:  begin ctl.fn = FN_ADD;  ctl.merge = 1'b1; end
            OP_SUB_P:  begin ctl.fn = FN_SUB;  ctl.merge = 1'b1; end
            OP_ADDS_P: begin ctl.fn = FN_ADDS; ctl.merge = 1'b1; end
            OP_AVGR_P: begin ctl.fn = FN_AVGR; ctl.merge = 1'b1; end
            default:   ctl.illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/simd_lane_unit.sv
module simd_lane_unit
    import simd_lane_pkg::*;
(
    input  op_ctl_t ctl,
    input  logic    sel,
    input  lane_t   src_a,
    input  lane_t   src_b,
    input  lane_t   dst,
    output lane_t   res
);
    lane_t val;

    always_comb begin
        case (ctl.fn)
            FN_ADD:   val = src_a + src_b;
            FN_SUB:   val = src_a - src_b;
            FN_ADDS:  val = clamp_lane(sext1(src_a) + sext1(src_b));
            FN_SUBS:  val = clamp_lane(sext1(src_a) - sext1(src_b));
            FN_NEG:   val = '0 - src_a;
            FN_ABS:   val = mag_lane(sext1(src_a));
            FN_ABSD:  val = mag_lane(sext1(src_a) - sext1(src_b));
            FN_ABSDU: val = mag_lane(zext1(src_a) - zext1(src_b));
            FN_AVGR:  val = avg_up(src_a, src_b);
            FN_MAXU:  val = (src_a > src_b) ? src_a : src_b;
            default:  val = dst;
        endcase
    end

    // Unselected lanes of a masked code and unassigned codes keep the destination
    always_comb begin
        if (ctl.illegal || (ctl.merge && !sel)) begin
            res = dst;
        end else begin
            res = val;
        end
    end
endmodule

// File: rtl/simd_lane_array.sv
module simd_lane_array
    import simd_lane_pkg::*;
#(
    parameter int NUM_LANES = 32,
    localparam int DATA_W   = NUM_LANES * LANE_W
) (
    input  op_ctl_t              ctl,
    input  logic [NUM_LANES-1:0] pred,
    input  logic [DATA_W-1:0]    src_a,
    input  logic [DATA_W-1:0]    src_b,
    input  logic [DATA_W-1:0]    dst,
    output logic [DATA_W-1:0]    res
);
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        simd_lane_unit lane_i (
            .ctl   (ctl),
            .sel   (pred[i]),
            .src_a (src_a[i*LANE_W +: LANE_W]),
            .src_b (src_b[i*LANE_W +: LANE_W]),
            .dst   (dst[i*LANE_W +: LANE_W]),
            .res   (res[i*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/simd_result_stage.sv
module simd_result_stage #(
    parameter bit OUT_REG = 1'b1,
    parameter int DATA_W  = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [DATA_W-1:0] data_in,
    input  logic              illegal_in,
    output logic              valid_out,
    output logic [DATA_W-1:0] data_out,
    output logic              illegal_out
);
    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_out   <= 1'b0;
                data_out    <= '0;
                illegal_out <= 1'b0;
            end else begin
                valid_out <= take;
                if (take) begin
                    data_out    <= data_in;
                    illegal_out <= illegal_in;
                end
            end
        end
    end else begin : g_comb
        assign valid_out   = take;
        assign data_out    = data_in;
        assign illegal_out = illegal_in;
    end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
    import simd_lane_pkg::*;
#(
    parameter int NUM_LANES = 32,
    parameter bit OUT_REG   = 1'b1,
    localparam int DATA_W   = NUM_LANES * LANE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [OP_W-1:0]      in_op,
    input  logic [DATA_W-1:0]    in_src_a,
    input  logic [DATA_W-1:0]    in_src_b,
    input  logic [DATA_W-1:0]    in_dst,
    input  logic [NUM_LANES-1:0] in_pred,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    out_result,
    output logic                 out_illegal
);
    op_ctl_t           ctl;
    logic [DATA_W-1:0] lane_res;
    logic              ready_q;
    logic              accept;

    always_ff @(posedge clk) begin
        if (rst) ready_q <= 1'b0;
        else     ready_q <= 1'b1;
    end

    assign in_ready = ready_q;
    assign accept   = in_valid && ready_q;

    simd_op_decode dec_i (
        .op  (in_op),
        .ctl (ctl)
    );

    simd_lane_array #(.NUM_LANES(NUM_LANES)) array_i (
        .ctl   (ctl),
        .pred  (in_pred),
        .src_a (in_src_a),
        .src_b (in_src_b),
        .dst   (in_dst),
        .res   (lane_res)
    );

    simd_result_stage #(.OUT_REG(OUT_REG), .DATA_W(DATA_W)) stage_i (
        .clk         (clk),
        .rst         (rst),
        .take        (accept),
        .data_in     (lane_res),
        .illegal_in  (ctl.illegal),
        .valid_out   (out_valid),
        .data_out    (out_result),
        .illegal_out (out_illegal)
    );
endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk
    import simd_lane_pkg::*;
#(
    parameter bit OUT_REG = 1'b1,
    parameter int DATA_W  = 512
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [OP_W-1:0]   in_op,
    input lane_t             a0,
    input lane_t             b0,
    input lane_t             d0,
    input logic              p0,
    input logic [DATA_W-1:0] in_dst,
    input logic              out_valid,
    input logic              out_illegal,
    input lane_t             res0,
    input logic [DATA_W-1:0] out_result
);
    if (OUT_REG) begin : g_reg
        // R10
        reset_quiet_chk: assert property (@(posedge clk) rst |=> !out_valid);
        // R10
        valid_needs_accept_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> $past(in_valid && in_ready));
        // R10
        accept_gives_valid_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_ready) |=> out_valid);
        // R9
        illegal_keeps_dst_chk: assert property (@(posedge clk) disable iff (rst)
            (out_valid && out_illegal) |-> out_result == $past(in_dst));
        // R9
        illegal_flag_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (out_illegal == ($past(in_op) >= 4'd14)));
        // R2
        clamp_sign_chk: assert property (@(posedge clk) disable iff (rst)
            (out_valid && $past(in_op) == OP_ADDS && !$past(a0[LANE_W-1])
             && !$past(b0[LANE_W-1])) |-> !res0[LANE_W-1]);
        // R3
        abs_range_chk: assert property (@(posedge clk) disable iff (rst)
            (out_valid && $past(in_op) == OP_ABS)
            |-> (!res0[LANE_W-1] || res0 == LANE_NEG_MIN));
        // R6
        maxu_bound_chk: assert property (@(posedge clk) disable iff (rst)
            (out_valid && $past(in_op) == OP_MAXU)
            |-> (res0 >= $past(a0) && res0 >= $past(b0)));
        // R7
        merge_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (out_valid && $past(in_op) >= 4'd10 && $past(in_op) <= 4'd13 && !$past(p0))
            |-> res0 == $past(d0));
    end else begin : g_comb
        // R10
        same_cycle_valid_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid == (in_valid && in_ready));
        // R9
        same_cycle_illegal_chk: assert property (@(posedge clk) disable iff (rst)
            (out_valid && out_illegal) |-> out_result == in_dst);
        // R7
        same_cycle_merge_chk: assert property (@(posedge clk) disable iff (rst)
            (out_valid && in_op >= 4'd10 && in_op <= 4'd13 && !p0) |-> res0 == d0);
        // R6
        same_cycle_maxu_chk: assert property (@(posedge clk) disable iff (rst)
            (out_valid && in_op == OP_MAXU) |-> (res0 >= a0 && res0 >= b0));
    end
endmodule

bind simd_lane_alu simd_lane_alu_chk #(
    .OUT_REG (OUT_REG),
    .DATA_W  (DATA_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_op       (in_op),
    .a0          (in_src_a[15:0]),
    .b0          (in_src_b[15:0]),
    .d0          (in_dst[15:0]),
    .p0          (in_pred[0]),
    .in_dst      (in_dst),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .res0        (out_result[15:0]),
    .out_result  (out_result)
);

// File: tb/simd_lane_alu_tb_top.sv
module simd_lane_alu_tb_top;
    localparam int NL = 32;
    localparam int DW = NL * 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [3:0]    in_op = 4'd0;
    logic [DW-1:0] in_src_a = '0;
    logic [DW-1:0] in_src_b = '0;
    logic [DW-1:0] in_dst = '0;
    logic [NL-1:0] in_pred = '0;
    logic          out_valid;
    logic [DW-1:0] out_result;
    logic          out_illegal;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    simd_lane_alu dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .in_dst(in_dst), .in_pred(in_pred), .out_valid(out_valid),
        .out_result(out_result), .out_illegal(out_illegal)
    );

    function automatic int clampi(int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int absi(int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic logic [15:0] ref_lane(int op, logic [15:0] a, logic [15:0] b,
                                             logic [15:0] d, logic p);
        int sa = $signed(a);
        int sb = $signed(b);
        int ua = a;
        int ub = b;
        int ud = d;
        int r;
        case (op)
            0:  r = ua + ub;
            1:  r = ua - ub;
            2:  r = clampi(sa + sb);
            3:  r = clampi(sa - sb);
            4:  r = -sa;
            5:  r = absi(sa);
            6:  r = absi(sa - sb);
            7:  r = absi(ua - ub);
            8:  r = (sa + sb + 1) >>> 1;
            9:  r = (ua > ub) ? ua : ub;
            10: r = p ? ua + ub : ud;
            11: r = p ? ua - ub : ud;
            12: r = p ? clampi(sa + sb) : ud;
            13: r = p ? ((sa + sb + 1) >>> 1) : ud;
            default: r = ud;
        endcase
        return r[15:0];
    endfunction

    function automatic logic [DW-1:0] ref_vec(int op, logic [DW-1:0] a, logic [DW-1:0] b,
                                              logic [DW-1:0] d, logic [NL-1:0] p);
        logic [DW-1:0] v;
        for (int i = 0; i < NL; i++)
            v[i*16 +: 16] = ref_lane(op, a[i*16 +: 16], b[i*16 +: 16], d[i*16 +: 16], p[i]);
        return v;
    endfunction

    function automatic logic [DW-1:0] noise(logic [31:0] seed);
        logic [31:0]   x = seed;
        logic [DW-1:0] v;
        for (int i = 0; i < NL; i++) begin
            x = x ^ (x << 13);
            x = x ^ (x >> 17);
            x = x ^ (x << 5);
            v[i*16 +: 16] = x[15:0] ^ x[31:16];
        end
        return v;
    endfunction

    task automatic check_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic check_vec(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one op at a falling edge, read it one full cycle later
    task automatic run_op(string req, int op, logic [DW-1:0] a, logic [DW-1:0] b,
                          logic [DW-1:0] d, logic [NL-1:0] p);
        @(negedge clk);
        in_op = op[3:0]; in_src_a = a; in_src_b = b; in_dst = d; in_pred = p;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_bit({req, " valid"}, out_valid, 1'b1);
        check_vec(req, out_result, ref_vec(op, a, b, d, p));
        check_bit({req, " flag"}, out_illegal, op >= 14);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_bit("R10 reset valid", out_valid, 1'b0);
        check_vec("R10 reset result", out_result, '0);
        check_bit("R10 reset ready", in_ready, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check_bit("R10 ready after reset", in_ready, 1'b1);
    endtask

    task automatic t_wrap();
        logic [DW-1:0] a = noise(32'h1234_5678);
        logic [DW-1:0] b = noise(32'h9abc_def1);
        a[15:0] = 16'hffff; b[15:0] = 16'h0001;
        a[31:16] = 16'h7000; b[31:16] = 16'h2000;
        a[47:32] = 16'h0000; b[47:32] = 16'h0001;
        run_op("R1 add", 0, a, b, noise(32'h5), '0);
        run_op("R1 sub", 1, a, b, noise(32'h6), '0);
    endtask

    task automatic t_clamp();
        logic [DW-1:0] a = noise(32'h0bad_cafe);
        logic [DW-1:0] b = noise(32'h1357_2468);
        a[15:0] = 16'h7000;  b[15:0] = 16'h2000;
        a[31:16] = 16'h9000; b[31:16] = 16'he000;
        a[47:32] = 16'h8000; b[47:32] = 16'h0001;
        a[63:48] = 16'h7fff; b[63:48] = 16'hffff;
        a[79:64] = 16'h0005; b[79:64] = 16'h0003;
        run_op("R2 adds", 2, a, b, '0, '0);
        run_op("R2 subs", 3, a, b, '0, '0);
    endtask

    task automatic t_negabs();
        logic [DW-1:0] a = noise(32'h7777_1111);
        a[15:0] = 16'h8000; a[31:16] = 16'h0001; a[47:32] = 16'hffff; a[63:48] = 16'h0000;
        run_op("R3 neg", 4, a, '0, '0, '0);
        run_op("R3 abs", 5, a, '0, '0, '0);
    endtask

    task automatic t_absd();
        logic [DW-1:0] a = noise(32'h2222_3333);
        logic [DW-1:0] b = noise(32'h4444_5555);
        a[15:0] = 16'h7fff; b[15:0] = 16'h8000;
        a[31:16] = 16'h0003; b[31:16] = 16'hfffe;
        run_op("R4 signed distance", 6, a, b, '0, '0);
        run_op("R4 unsigned distance", 7, a, b, '0, '0);
    endtask

    task automatic t_avg();
        logic [DW-1:0] a = noise(32'h6666_9999);
        logic [DW-1:0] b = noise(32'h0101_0202);
        a[15:0] = 16'd3;     b[15:0] = 16'd4;
        a[31:16] = 16'd5;    b[31:16] = 16'd2;
        a[47:32] = 16'hfffc; b[47:32] = 16'hfffd;
        a[63:48] = 16'd7;    b[63:48] = 16'd8;
        a[79:64] = 16'h7fff; b[79:64] = 16'h7fff;
        run_op("R5 average", 8, a, b, '0, '0);
    endtask

    task automatic t_maxu();
        logic [DW-1:0] a = noise(32'h3141_5926);
        logic [DW-1:0] b = noise(32'h2718_2818);
        a[15:0] = 16'h8000; b[15:0] = 16'h0001;
        run_op("R6 unsigned max", 9, a, b, '0, '0);
    endtask

    task automatic t_pred();
        logic [DW-1:0] a = noise(32'hfeed_0001);
        logic [DW-1:0] b = noise(32'hfeed_0002);
        logic [DW-1:0] d = noise(32'hfeed_0003);
        run_op("R7 masked add none", 10, a, b, d, 32'h0000_0000);
        check_vec("R7 no lane zeroed", out_result, d);
        run_op("R7 masked add all", 10, a, b, d, 32'hffff_ffff);
        run_op("R7 masked sub alt", 11, a, b, d, 32'haaaa_5555);
        run_op("R7 masked adds", 12, a, b, d, 32'h0f0f_f0f0);
        run_op("R7 masked average", 13, a, b, d, 32'h8000_0001);
    endtask

    task automatic t_pred_ignored();
        logic [DW-1:0] a = noise(32'hc0de_0001);
        logic [DW-1:0] b = noise(32'hc0de_0002);
        logic [DW-1:0] d = noise(32'hc0de_0003);
        run_op("R8 plain add mask clear", 0, a, b, d, 32'h0000_0000);
        run_op("R8 plain add mask set", 0, a, b, d, 32'hffff_ffff);
        run_op("R8 plain average mask mixed", 8, a, b, d, 32'h1234_5678);
    endtask

    task automatic t_illegal();
        logic [DW-1:0] d = noise(32'hdead_beef);
        run_op("R9 code 14", 14, noise(32'h11), noise(32'h22), d, 32'hffff_ffff);
        check_vec("R9 code 14 keeps dst", out_result, d);
        run_op("R9 code 15", 15, noise(32'h33), noise(32'h44), d, '0);
        run_op("R9 flag clears", 1, noise(32'h55), noise(32'h66), d, '0);
    endtask

    task automatic t_timing();
        logic [DW-1:0] a1 = noise(32'haaaa_0001);
        logic [DW-1:0] a2 = noise(32'haaaa_0002);
        logic [DW-1:0] b = noise(32'haaaa_0003);
        @(negedge clk);
        check_bit("R10 pulse ends", out_valid, 1'b0);
        @(negedge clk);
        in_op = 4'd0; in_src_a = a1; in_src_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_op = 4'd1; in_src_a = a2;
        check_bit("R10 first valid", out_valid, 1'b1);
        check_vec("R10 first result", out_result, ref_vec(0, a1, b, '0, '0));
        @(negedge clk);
        in_valid = 1'b0;
        check_bit("R10 second valid", out_valid, 1'b1);
        check_vec("R10 second result", out_result, ref_vec(1, a2, b, '0, '0));
        @(negedge clk);
        check_bit("R10 idle no valid", out_valid, 1'b0);
        repeat (2) @(negedge clk);
        check_bit("R10 still idle", out_valid, 1'b0);
    endtask

    task automatic t_sweep();
        for (int op = 0; op < 16; op++)
            run_op("R1 R7 sweep", op, noise(32'h100 + op), noise(32'h200 + op),
                   noise(32'h300 + op), noise(32'h400 + op));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_wrap();
        t_clamp();
        t_negabs();
        t_absd();
        t_avg();
        t_maxu();
        t_pred();
        t_pred_ignored();
        t_illegal();
        t_timing();
        t_sweep();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule